// File: doc/BRIEF.md
# Interrupt Delivery and Exception Entry Unit

This block keeps the pending state for four interrupt sources of a simple processor: a timer and three external lines, one for I/O and two for inter-processor signalling. Raise and clear requests update a per-source pending bit. They also update the interrupt-pending bits that the cause register shows. Each cycle the unit looks at the registered pending bits from the lowest source index up. It takes the first source that the global enable, the exception level, the error level and the source's own mask bit allow.

When a source is taken, the unit performs exception entry. It stores the current PC into the exception PC register and sets the exception level. It records the branch-delay flag that the core supplies and writes the interrupt exception code, which is 0. It drives a new PC: a kernel-segment base plus 0x200 when the cause vector-select bit is 1, and plus 0x180 when it is 0. The core returns from the handler by pulsing `exc_ret`, which clears the exception level.

Top module: `irq_entry_unit`

## Requirements
- R1: After reset, the pending bits, `cause_ip`, `cause_ti`, `cause_bd`, `cause_exc`, `exl`, `epc`, `new_pc`, `deliver` and `nest_err` are all 0.
- R2: A timer raise sets `cause_ip[5]`, `cause_ti` and `tmr_pending` one cycle later. A timer clear resets all three. A raise and a clear for the timer in the same cycle leave them cleared.
- R3: With `ext_req_vld` high, `ext_req_num` +2, +3 and +4 (signed 4-bit) set `cause_ip[0]`, `cause_ip[1]` and `cause_ip[2]` and make the I/O, IPI-1 and IPI-2 sources pending. The values -2, -3 and -4 clear the same bits. Every other value changes nothing.
- R4: A source is taken only when `sts_ie` is 1, `sts_erl` is 0, `exl` is 0, and its mask bit in `sts_im` is 1. The mask bit is `sts_im[5]` for the timer and `sts_im[0..2]` for I/O, IPI-1 and IPI-2.
- R5: Source indices are timer 0, I/O 1, IPI-1 2 and IPI-2 3. At most one source is taken per cycle, the lowest allowed index wins, and the taken source's pending bit is cleared, so it is never taken twice for one raise. `dlv_src` gives the index taken.
- R6: In the cycle after a source is taken, `deliver` is high for one cycle. In that cycle `exl` is 1, `epc` holds the `cur_pc` value from the cycle the source was taken, `cause_bd` equals the `cur_bd` value from that cycle, and `cause_exc` is 0.
- R7: `new_pc` is `KSEG_BASE`+0x200 when `cause_iv` was 1 in the cycle the source was taken, and `KSEG_BASE`+0x180 when it was 0. The default `KSEG_BASE` is 0x80000000.
- R8: Taking a source does not clear its `cause_ip` bit. Only a clear request does.
- R9: The choice of source uses only pending state registered before the current cycle. A raise can therefore produce `deliver` no earlier than two cycles after the raise is presented.
- R10: A pulse on `exc_ret` clears `exl`, so pending sources can be taken again.
- R11: `nest_err` flags an entry attempted while `exl` is already 1. The gating rule makes that case unreachable, so `nest_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_raise | input | 1 | Timer raise request |
| tmr_clear | input | 1 | Timer clear request |
| ext_req_vld | input | 1 | External request valid |
| ext_req_num | input | 4 | Signed external line number: positive raises, negative clears |
| sts_ie | input | 1 | Status global interrupt enable |
| sts_erl | input | 1 | Status error level |
| sts_im | input | 6 | Status per-line mask, bit n for IRQn |
| cause_iv | input | 1 | Cause vector-select bit |
| cur_pc | input | 32 | Current core PC |
| cur_bd | input | 1 | Current instruction is in a branch delay slot |
| exc_ret | input | 1 | Return from exception; clears exl |
| deliver | output | 1 | One-cycle pulse on exception entry |
| dlv_src | output | 2 | Index of the source taken |
| new_pc | output | 32 | Vector PC for the entry |
| epc | output | 32 | Saved exception PC |
| exl | output | 1 | Exception level |
| cause_ip | output | 6 | Cause interrupt-pending bits IRQ0..IRQ5 |
| cause_ti | output | 1 | Cause timer-interrupt flag |
| cause_bd | output | 1 | Cause branch-delay flag |
| cause_exc | output | 5 | Cause exception code |
| tmr_pending | output | 1 | Timer pending bit |
| nest_err | output | 1 | Entry attempted with exl already set |

## Verification
Some internal faults do not show up on the ports right away. A pending bit that stays stuck after its source is taken is one example. It shows up only as a second `deliver` for the same source after the next `exc_ret`. A lost pending bit shows up as a `deliver` that never arrives. The scoreboard therefore matches every `deliver` pulse against an ordered list of expected entries, and it treats any extra pulse as a failure. A wrong pick among several pending sources shows up at the first entry as the wrong `dlv_src` and in the order of the entries that follow. A gating fault shows up as a pulse two cycles after a raise while one of the gating conditions should be blocking it.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int unsigned NSRC   = 4;
  localparam int unsigned SRC_W  = 2;
  localparam int unsigned NIRQ   = 6;
  localparam int unsigned EXC_W  = 5;
  localparam logic [EXC_W-1:0] EXC_INT = '0;

  typedef enum logic [SRC_W-1:0] {
    SRC_TMR  = 2'd0,
    SRC_IO   = 2'd1,
    SRC_IPI1 = 2'd2,
    SRC_IPI2 = 2'd3
  } src_e;

  // cause/status IRQ line used by each source
  function automatic int unsigned src_irq(input int unsigned s);
    return (s == 0) ? 5 : s - 1;
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_entry_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tmr_raise,
  input  logic                   tmr_clear,
  input  logic                   ext_req_vld,
  input  logic signed [3:0]      ext_req_num,
  input  logic [NSRC-1:0]        taken,
  output logic [NSRC-1:0]        pend,
  output logic [NIRQ-1:0]        ip
);
  logic [NSRC-1:0] set_v, clr_v, pend_n, line_q, line_n;

  assign set_v[0] = tmr_raise;
  assign clr_v[0] = tmr_clear;

  generate
    for (genvar s = 1; s < NSRC; s++) begin : g_ext
      localparam logic signed [3:0] NUM = 4'(s + 1);
      assign set_v[s] = ext_req_vld && (ext_req_num == NUM);
      assign clr_v[s] = ext_req_vld && (ext_req_num == -NUM);
    end
  endgenerate

  always_comb begin
    pend_n = ((pend & ~taken) | set_v) & ~clr_v;
    line_n = (line_q | set_v) & ~clr_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      line_q <= '0;
    end else begin
      pend   <= pend_n;
      line_q <= line_n;
    end
  end

  always_comb begin
    ip = '0;
    for (int s = 0; s < NSRC; s++) ip[src_irq(s)] = line_q[s];
  end

  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_raise && tmr_clear) |=> (!pend[0] && !ip[5]));
  a_r8_keep_line: assert property (@(posedge clk) disable iff (!rst_n)
    (taken[0] && !tmr_clear && ip[5]) |=> ip[5]);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_entry_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        pend,
  input  logic                   sts_ie,
  input  logic                   sts_erl,
  input  logic                   exl,
  input  logic [NIRQ-1:0]        sts_im,
  output logic [NSRC-1:0]        grant,
  output logic                   fire,
  output logic [SRC_W-1:0]       grant_idx
);
  logic [NSRC-1:0] elig;
  logic            open_gate;

  assign open_gate = sts_ie && !sts_erl && !exl;

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_elig
      assign elig[s] = pend[s] && open_gate && sts_im[src_irq(s)];
    end
  endgenerate

  // isolate lowest set bit
  assign grant = elig & (~elig + NSRC'(1));
  assign fire  = |elig;

  always_comb begin
    grant_idx = '0;
    for (int s = NSRC-1; s >= 0; s--)
      if (elig[s]) grant_idx = SRC_W'(s);
  end

  a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r5_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~pend) == '0);
  a_r4_gate: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (sts_ie && !sts_erl && !exl));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int unsigned    XLEN      = 32,
  parameter logic [31:0]    KSEG_BASE = 32'h8000_0000,
  parameter logic [31:0]    OFF_IV    = 32'h200,
  parameter logic [31:0]    OFF_STD   = 32'h180
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [SRC_W-1:0]   grant_idx,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic               cur_bd,
  input  logic               cause_iv,
  input  logic               exc_ret,
  output logic               deliver,
  output logic [SRC_W-1:0]   dlv_src,
  output logic [XLEN-1:0]    new_pc,
  output logic [XLEN-1:0]    epc,
  output logic               exl,
  output logic               bd,
  output logic [EXC_W-1:0]   exc,
  output logic               nest_err
);
  localparam logic [XLEN-1:0] VEC_IV  = XLEN'(KSEG_BASE + OFF_IV);
  localparam logic [XLEN-1:0] VEC_STD = XLEN'(KSEG_BASE + OFF_STD);

  logic               exl_n, bd_n, err_n, save_en;
  logic [XLEN-1:0]    epc_n, pc_n;
  logic [EXC_W-1:0]   exc_n;

  always_comb begin
    save_en = fire && !exl;
    exl_n   = exl;
    if (fire)         exl_n = 1'b1;
    else if (exc_ret) exl_n = 1'b0;
    epc_n   = save_en ? cur_pc : epc;
    bd_n    = save_en ? cur_bd : bd;
    exc_n   = fire ? EXC_INT : exc;
    pc_n    = fire ? (cause_iv ? VEC_IV : VEC_STD) : new_pc;
    err_n   = nest_err | (fire && exl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deliver  <= 1'b0;
      dlv_src  <= '0;
      new_pc   <= '0;
      epc      <= '0;
      exl      <= 1'b0;
      bd       <= 1'b0;
      exc      <= '0;
      nest_err <= 1'b0;
    end else begin
      deliver  <= fire;
      if (fire) dlv_src <= grant_idx;
      new_pc   <= pc_n;
      epc      <= epc_n;
      exl      <= exl_n;
      bd       <= bd_n;
      exc      <= exc_n;
      nest_err <= err_n;
    end
  end

  a_r6_entry_state: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |-> (exl && exc == EXC_INT));
  a_r6_epc_saved: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (epc == $past(cur_pc)));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |=> !deliver);
  a_r7_vector: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |-> (new_pc == VEC_IV || new_pc == VEC_STD));
  a_r10_ret_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ret && !fire) |=> !exl);
  a_r11_no_nest: assert property (@(posedge clk) disable iff (!rst_n)
    !nest_err);
endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
  import irq_entry_pkg::*;
#(
  parameter logic [31:0] KSEG_BASE = 32'h8000_0000
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tmr_raise,
  input  logic               tmr_clear,
  input  logic               ext_req_vld,
  input  logic signed [3:0]  ext_req_num,
  input  logic               sts_ie,
  input  logic               sts_erl,
  input  logic [5:0]         sts_im,
  input  logic               cause_iv,
  input  logic [31:0]        cur_pc,
  input  logic               cur_bd,
  input  logic               exc_ret,
  output logic               deliver,
  output logic [1:0]         dlv_src,
  output logic [31:0]        new_pc,
  output logic [31:0]        epc,
  output logic               exl,
  output logic [5:0]         cause_ip,
  output logic               cause_ti,
  output logic               cause_bd,
  output logic [4:0]         cause_exc,
  output logic               tmr_pending,
  output logic               nest_err
);
  logic [NSRC-1:0]  pend, grant;
  logic             fire;
  logic [SRC_W-1:0] grant_idx;

  irq_pend_bank u_bank (
    .clk(clk), .rst_n(rst_n),
    .tmr_raise(tmr_raise), .tmr_clear(tmr_clear),
    .ext_req_vld(ext_req_vld), .ext_req_num(ext_req_num),
    .taken(grant), .pend(pend), .ip(cause_ip)
  );

  irq_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend),
    .sts_ie(sts_ie), .sts_erl(sts_erl), .exl(exl), .sts_im(sts_im),
    .grant(grant), .fire(fire), .grant_idx(grant_idx)
  );

  irq_entry_seq #(.XLEN(32), .KSEG_BASE(KSEG_BASE)) u_seq (
    .clk(clk), .rst_n(rst_n), .fire(fire), .grant_idx(grant_idx),
    .cur_pc(cur_pc), .cur_bd(cur_bd), .cause_iv(cause_iv), .exc_ret(exc_ret),
    .deliver(deliver), .dlv_src(dlv_src), .new_pc(new_pc), .epc(epc),
    .exl(exl), .bd(cause_bd), .exc(cause_exc), .nest_err(nest_err)
  );

  assign cause_ti    = cause_ip[src_irq(0)];
  assign tmr_pending = pend[0];

  a_r9_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_raise && !tmr_pending) |=> !(deliver && dlv_src == 2'd0));
endmodule

// File: tb/irq_entry_unit_tb_top.sv
module irq_entry_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic tmr_raise, tmr_clear, ext_req_vld, sts_ie, sts_erl, cause_iv, cur_bd, exc_ret;
  logic signed [3:0] ext_req_num;
  logic [5:0] sts_im;
  logic [31:0] cur_pc;
  logic deliver, exl, cause_ti, cause_bd, tmr_pending, nest_err;
  logic [1:0] dlv_src;
  logic [31:0] new_pc, epc;
  logic [5:0] cause_ip;
  logic [4:0] cause_exc;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [1:0] src; logic [31:0] pc; logic [31:0] epc; logic bd; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  irq_entry_unit dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] expv);
    chk(act === expv, req, act, expv);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_entry(input logic [1:0] s, input logic [31:0] pc, input logic [31:0] e, input logic b);
    exp_t x;
    x.src = s; x.pc = pc; x.epc = e; x.bd = b;
    q.push_back(x);
  endtask

  task automatic ext(input logic signed [3:0] num);
    ext_req_vld = 1'b1; ext_req_num = num;
    cyc(1);
    ext_req_vld = 1'b0;
  endtask

  // monitor: compare each entry against the scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && deliver === 1'b1) begin
      if (q.size() == 0) begin
        chk(0, "R4 unexpected entry", {30'd0, dlv_src}, 32'hFFFF_FFFF);
      end else begin
        exp_t x;
        x = q.pop_front();
        eq("R5 source", {30'd0, dlv_src}, {30'd0, x.src});
        eq("R7 vector", new_pc, x.pc);
        eq("R6 epc", epc, x.epc);
        eq("R6 bd", {31'd0, cause_bd}, {31'd0, x.bd});
        eq("R6 exl", {31'd0, exl}, 32'd1);
        eq("R6 exccode", {27'd0, cause_exc}, 32'd0);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    tmr_raise = 0; tmr_clear = 0; ext_req_vld = 0; ext_req_num = '0;
    sts_ie = 0; sts_erl = 0; sts_im = '0; cause_iv = 0;
    cur_pc = 32'h1000; cur_bd = 0; exc_ret = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    eq("R1 cause_ip", {26'd0, cause_ip}, 32'd0);
    eq("R1 exl", {31'd0, exl}, 32'd0);
    eq("R1 epc", epc, 32'd0);
    eq("R1 new_pc", new_pc, 32'd0);
    eq("R1 deliver", {31'd0, deliver}, 32'd0);
    eq("R1 tmr_pending", {31'd0, tmr_pending}, 32'd0);
    eq("R1 misc", {26'd0, cause_exc, cause_bd}, 32'd0);

    // R2 timer raise
    tmr_raise = 1; cyc(1); tmr_raise = 0;
    eq("R2 ip after raise", {26'd0, cause_ip}, 32'h20);
    eq("R2 ti", {31'd0, cause_ti}, 32'd1);
    eq("R2 pending", {31'd0, tmr_pending}, 32'd1);

    // R4 gating: each blocking condition alone
    cyc(3);
    sts_ie = 1; sts_erl = 1; sts_im = 6'h3F; cyc(3);
    sts_erl = 0; sts_im = 6'h1F; cyc(3);
    eq("R4 still pending when blocked", {31'd0, tmr_pending}, 32'd1);

    // first entry, standard vector
    cur_bd = 1;
    expect_entry(2'd0, 32'h8000_0180, 32'h1000, 1'b1);
    sts_im = 6'h3F; cyc(1);
    eq("R6 exl set", {31'd0, exl}, 32'd1);
    eq("R5 timer pending cleared", {31'd0, tmr_pending}, 32'd0);
    eq("R8 ip kept", {26'd0, cause_ip}, 32'h20);
    cur_bd = 0; cyc(1);
    eq("R6 one-cycle pulse", {31'd0, deliver}, 32'd0);

    // R2 clear, and raise+clear together
    tmr_clear = 1; cyc(1); tmr_clear = 0;
    eq("R2 ip cleared", {26'd0, cause_ip}, 32'd0);
    eq("R2 ti cleared", {31'd0, cause_ti}, 32'd0);
    tmr_raise = 1; tmr_clear = 1; cyc(1); tmr_raise = 0; tmr_clear = 0;
    eq("R2 clear wins pending", {31'd0, tmr_pending}, 32'd0);
    eq("R2 clear wins ip", {26'd0, cause_ip}, 32'd0);

    // R5 priority: load all sources while exl holds them off
    ext(4'sd4); ext(4'sd3); ext(4'sd2);
    tmr_raise = 1; cyc(1); tmr_raise = 0;
    eq("R3 ip all lines", {26'd0, cause_ip}, 32'h27);
    cause_iv = 1;
    for (int s = 0; s < 4; s++) begin
      cur_pc = 32'h2000 + 32'(s * 4);
      cur_bd = s[0];
      expect_entry(2'(s), 32'h8000_0200, cur_pc, s[0]);
      exc_ret = 1; cyc(1); exc_ret = 0;
      eq("R10 exl cleared by return", {31'd0, exl}, 32'd0);
      cyc(2);
    end
    exc_ret = 1; cyc(1); exc_ret = 0;
    cyc(3);
    eq("R5 no repeat entries, queue empty", 32'(q.size()), 32'd0);
    eq("R8 ip kept after entries", {26'd0, cause_ip}, 32'h27);

    // R3 ignored numbers (enabled, exl clear: a bad raise would show as an entry)
    ext(4'sd5); ext(-4'sd5); ext(4'sd0); ext(4'sd1); ext(4'sd7); ext(-4'sd1);
    cyc(3);
    eq("R3 ignored numbers", {26'd0, cause_ip}, 32'h27);
    ext(-4'sd2); ext(-4'sd3); ext(-4'sd4);
    tmr_clear = 1; cyc(1); tmr_clear = 0;
    eq("R3 clears", {26'd0, cause_ip}, 32'd0);

    // R9 latency: entry two cycles after raise
    cur_pc = 32'h3000; cur_bd = 0;
    expect_entry(2'd1, 32'h8000_0200, 32'h3000, 1'b0);
    ext(4'sd2);
    eq("R9 no entry after one cycle", {31'd0, deliver}, 32'd0);
    cyc(1);
    eq("R9 entry after two cycles", {31'd0, deliver}, 32'd1);
    cyc(2);
    eq("R9 scoreboard drained", 32'(q.size()), 32'd0);
    eq("R11 nest flag", {31'd0, nest_err}, 32'd0);
    finish_run();
  end
endmodule